// File: doc/BRIEF.md
# Teletext Bit Request and Capture Sequencer

This block sits in the 27 MHz crystal-clock domain, between an external teletext bit source and the line inserter of a video encoder. Software selects which video lines carry text. It uses one line mask for the first field and another for the second. On a selected line, the block opens an insertion window a programmable number of clocks after line start. Inside that window it sends the source one request pulse per wanted bit. The pulses are spaced by a phase accumulator, so their average rate approximates the teletext bit rate.

The window length depends on the chosen teletext standard. Each length includes the clock run-in bits. The source answers each request after a fixed latency. The block samples the data input that many clocks after the request rises. It then passes each sampled bit downstream with a one-cycle strobe, in arrival order.

A mode bit turns the request pin into a free-running clock at half the crystal rate. Teletext is suppressed while real-time control is active, or when the function is switched off.

Top module: `ttx_req_gen`

## Requirements
- R1: During and right after reset, `ttx_req`, `bit_valid` and `win_active` are low.
- R2: A window is armed only on a `vt_line_start` pulse. At that pulse `vt_line` must be below N_LINES, and bit `vt_line` of `cfg_lines_f1` (when `vt_field`=0) or of `cfg_lines_f2` (when `vt_field`=1) must be set. The function must also be enabled, with `cfg_enable`=1, `cfg_rtc_mode`=0 and `cfg_clkout_mode`=0.
- R3: `win_active` goes high `cfg_start_dly`+2 cycles after the cycle in which the arming `vt_line_start` is high. The accumulator starts from zero at that point.
- R4: Each window issues exactly 360 request pulses for `cfg_std`=0, 296 for `cfg_std`=1, and 288 for `cfg_std`=2 or 3. `win_active` is already low in the cycle in which the last pulse is high.
- R5: In every active cycle the window adds `cfg_phase_inc` to a PHASE_W-bit accumulator. Each carry out of the accumulator produces a one-cycle `ttx_req` pulse in the next cycle. `cfg_phase_inc` must be below 2^(PHASE_W-1).
- R6: A `vt_line_start` pulse that arrives while a window is waiting or running has no effect. The open window still completes its full count.
- R7: When `ttx_req` is high in cycle k, `ttx_data` is sampled at the clock edge that ends cycle k+`cfg_latency`. That value appears on `bit_out` with `bit_valid` high for exactly the next cycle.
- R8: With `cfg_clkout_mode`=1, `ttx_req` toggles on every clock edge and is high after the first edge. No window opens and `bit_valid` stays low.
- R9: If `cfg_enable` goes low or `cfg_rtc_mode` goes high, any open window closes at the next edge and no further requests are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz crystal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Teletext insertion enabled |
| cfg_rtc_mode | input | 1 | Real-time control active; suppresses teletext |
| cfg_clkout_mode | input | 1 | Request pin outputs a half-rate clock |
| cfg_std | input | 2 | Standard: 0 PAL WST, 1 NTSC WST, 2/3 NABTS |
| cfg_phase_inc | input | PHASE_W | Accumulator increment per clock |
| cfg_start_dly | input | DLY_W | Clocks from line start to window open |
| cfg_latency | input | LAT_W | Source latency in clocks |
| cfg_lines_f1 | input | N_LINES | Line enable mask, first field |
| cfg_lines_f2 | input | N_LINES | Line enable mask, second field |
| vt_field | input | 1 | Current field (0 first, 1 second) |
| vt_line | input | LINE_W | Current line number |
| vt_line_start | input | 1 | One-cycle pulse at start of line |
| ttx_data | input | 1 | Serial bit from the teletext source |
| ttx_req | output | 1 | Bit request pulses or half-rate clock |
| bit_out | output | 1 | Captured bit |
| bit_valid | output | 1 | One-cycle strobe for `bit_out` |
| win_active | output | 1 | Insertion window running |

## Verification
The assertions assume that the phase increment is nonzero and below half the accumulator range. That keeps request pulses separated by at least one low cycle. They also assume the configuration stays steady while a window is open, except for the enable and mode bits. The stimulus only uses increments up to 32767 with a 16-bit accumulator. It changes the standard, delay, latency and masks only between windows. It flips the enable, real-time-control and clock-out bits deliberately, so that the abort and clock paths are exercised.

// File: rtl/ttx_pkg.sv
// Shared types and helpers for the teletext request sequencer.
// Assumes a 2-bit standard code; code 3 is treated like NABTS.
package ttx_pkg;
    localparam int CNT_W = 9;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_WAIT = 2'd1,
        W_RUN  = 2'd2
    } win_state_t;

    // Window length in bits (run-in included) for a standard code.
    function automatic logic [CNT_W-1:0] std_bits(input logic [1:0] std);
        case (std)
            2'd0:    std_bits = CNT_W'(360);
            2'd1:    std_bits = CNT_W'(296);
            default: std_bits = CNT_W'(288);
        endcase
    endfunction
endpackage

// File: rtl/ttx_bit_pacer.sv
// Phase accumulator that paces request pulses.
// Adds the increment on every cycle that 'run' is high and reports the carry.
// Assumes 'clear' and 'run' are never high together.
module ttx_bit_pacer #(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               run,
    input  logic [PHASE_W-1:0] inc,
    output logic               carry
);
    logic [PHASE_W-1:0] acc;
    logic [PHASE_W:0]   sum;

    assign sum   = {1'b0, acc} + {1'b0, inc};
    assign carry = sum[PHASE_W];

    // Accumulator: zeroed at window start, advanced while running.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) acc <= '0;
        else if (run)        acc <= sum[PHASE_W-1:0];
    end
endmodule

// File: rtl/ttx_window.sv
// Insertion window control: line/field selection, start delay, bit count.
// Assumes vt_line_start is a single-cycle pulse and that the config is steady
// while a window is open.
module ttx_window
    import ttx_pkg::*;
#(
    parameter int LINE_W  = 10,
    parameter int N_LINES = 32,
    parameter int DLY_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               line_start,
    input  logic               field,
    input  logic [LINE_W-1:0]  line_num,
    input  logic [N_LINES-1:0] set_f1,
    input  logic [N_LINES-1:0] set_f2,
    input  logic [DLY_W-1:0]   start_dly,
    input  logic [1:0]         std,
    input  logic               carry,
    output logic               acc_clear,
    output logic               acc_run,
    output logic               issue,
    output logic               active
);
    localparam int IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

    win_state_t       state;
    logic [DLY_W-1:0] dly_cnt;
    logic [CNT_W-1:0] bits_left;
    logic             line_hit;
    logic [IDX_W-1:0] idx;

    assign idx       = line_num[IDX_W-1:0];
    assign line_hit  = (line_num < LINE_W'(N_LINES)) && (field ? set_f2[idx] : set_f1[idx]);
    assign acc_clear = (state == W_WAIT) && en && (dly_cnt == '0);
    assign acc_run   = (state == W_RUN) && en;
    assign issue     = acc_run && carry;
    assign active    = (state == W_RUN);

    // Window sequencing: arm on enabled line, wait, count bits, close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= W_IDLE;
            dly_cnt   <= '0;
            bits_left <= '0;
        end else if (!en) begin
            state <= W_IDLE;
        end else begin
            case (state)
                W_IDLE: if (line_start && line_hit) begin
                    state   <= W_WAIT;
                    dly_cnt <= start_dly;
                end
                W_WAIT: if (dly_cnt == '0) begin
                    state     <= W_RUN;
                    bits_left <= std_bits(std);
                end else begin
                    dly_cnt <= dly_cnt - 1'b1;
                end
                W_RUN: if (issue) begin
                    bits_left <= bits_left - 1'b1;
                    if (bits_left == CNT_W'(1)) state <= W_IDLE;
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    // R9: a disabled block returns to idle at the next edge.
    p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == W_IDLE);
    // R3: an expired start delay opens the window.
    p_open_after_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == W_WAIT && en && dly_cnt == '0) |=> state == W_RUN);
    // R4: a running window always has bits left to request.
    p_run_has_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state == W_RUN |-> bits_left != '0);
    // R6: a running window persists regardless of line starts until its last bit.
    p_run_persists_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == W_RUN && en && !(issue && bits_left == CNT_W'(1))) |=> state == W_RUN);
endmodule

// File: rtl/ttx_sampler.sv
// Latency-matched capture of returned bits.
// Delays each request by the programmed latency and samples the data input.
// Assumes latency stays steady while samples are in flight.
module ttx_sampler #(
    parameter int LAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [LAT_W-1:0] latency,
    input  logic             data,
    input  logic             clkout_mode,
    output logic             bit_out,
    output logic             bit_valid
);
    localparam int DEPTH = (1 << LAT_W) - 1;

    logic [DEPTH-1:0] hist;
    logic             tap;

    assign tap = (latency == '0) ? req : hist[latency - 1'b1];

    // Request history: bit i holds the request i+1 cycles ago.
    generate
        if (DEPTH == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) hist <= '0;
                else        hist <= req;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) hist <= '0;
                else        hist <= {hist[DEPTH-2:0], req};
            end
        end
    endgenerate

    // Capture: register the data bit and its strobe on a matured request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_out   <= 1'b0;
            bit_valid <= 1'b0;
        end else begin
            bit_valid <= tap && !clkout_mode;
            if (tap && !clkout_mode) bit_out <= data;
        end
    end

    // R8: no bit is delivered while the pin carries the clock.
    p_no_valid_clkout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(clkout_mode)) |-> !bit_valid);
endmodule

// File: rtl/ttx_req_gen.sv
// Teletext bit request generator, top level.
// Drives bit requests on selected lines, captures returned bits, and can
// instead output a half-rate clock. Assumes cfg_phase_inc < 2^(PHASE_W-1).
module ttx_req_gen #(
    parameter int PHASE_W = 16,
    parameter int LINE_W  = 10,
    parameter int N_LINES = 32,
    parameter int DLY_W   = 12,
    parameter int LAT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic               cfg_rtc_mode,
    input  logic               cfg_clkout_mode,
    input  logic [1:0]         cfg_std,
    input  logic [PHASE_W-1:0] cfg_phase_inc,
    input  logic [DLY_W-1:0]   cfg_start_dly,
    input  logic [LAT_W-1:0]   cfg_latency,
    input  logic [N_LINES-1:0] cfg_lines_f1,
    input  logic [N_LINES-1:0] cfg_lines_f2,
    input  logic               vt_field,
    input  logic [LINE_W-1:0]  vt_line,
    input  logic               vt_line_start,
    input  logic               ttx_data,
    output logic               ttx_req,
    output logic               bit_out,
    output logic               bit_valid,
    output logic               win_active
);
    logic en, carry, acc_clear, acc_run, issue;
    logic req_q, clk_div;

    assign en = cfg_enable && !cfg_rtc_mode && !cfg_clkout_mode;

    ttx_window #(.LINE_W(LINE_W), .N_LINES(N_LINES), .DLY_W(DLY_W)) u_win (
        .clk(clk), .rst_n(rst_n), .en(en), .line_start(vt_line_start),
        .field(vt_field), .line_num(vt_line), .set_f1(cfg_lines_f1),
        .set_f2(cfg_lines_f2), .start_dly(cfg_start_dly), .std(cfg_std),
        .carry(carry), .acc_clear(acc_clear), .acc_run(acc_run),
        .issue(issue), .active(win_active)
    );

    ttx_bit_pacer #(.PHASE_W(PHASE_W)) u_pacer (
        .clk(clk), .rst_n(rst_n), .clear(acc_clear), .run(acc_run),
        .inc(cfg_phase_inc), .carry(carry)
    );

    ttx_sampler #(.LAT_W(LAT_W)) u_smp (
        .clk(clk), .rst_n(rst_n), .req(req_q), .latency(cfg_latency),
        .data(ttx_data), .clkout_mode(cfg_clkout_mode),
        .bit_out(bit_out), .bit_valid(bit_valid)
    );

    // Request pulse register and half-rate clock divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            clk_div <= 1'b0;
        end else begin
            req_q   <= issue;
            clk_div <= cfg_clkout_mode ? !clk_div : 1'b0;
        end
    end

    assign ttx_req = cfg_clkout_mode ? clk_div : req_q;

    // R5: request pulses are one cycle wide with a gap after each.
    p_req_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);
    // R8: in clock mode the pin changes on every edge.
    p_clk_toggles_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cfg_clkout_mode && $past(cfg_clkout_mode)) |-> ttx_req != $past(ttx_req));
    // R1: nothing is active right after reset.
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!req_q && !win_active && !bit_valid));
endmodule

// File: tb/ttx_req_gen_test.sv
module ttx_req_gen_test;
    localparam int PW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic en = 1'b0, rtc = 1'b0, cko = 1'b0;
    logic [1:0] std = 2'd0;
    logic [PW-1:0] inc = 16'd16837;
    logic [11:0] sdly = 12'd5;
    logic [3:0] lat = 4'd3;
    logic [31:0] set1 = '0, set2 = '0;
    logic fld = 1'b0, ls = 1'b0, din = 1'b0;
    logic [9:0] line = '0;
    logic req, bout, bval, wact;

    int checks = 0, fails = 0, cyc = 0, pulses = 0;
    bit prev_req = 0, done = 0;
    logic [15:0] lfsr = 16'hACE1;

    ttx_req_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(en), .cfg_rtc_mode(rtc),
        .cfg_clkout_mode(cko), .cfg_std(std), .cfg_phase_inc(inc),
        .cfg_start_dly(sdly), .cfg_latency(lat), .cfg_lines_f1(set1),
        .cfg_lines_f2(set2), .vt_field(fld), .vt_line(line),
        .vt_line_start(ls), .ttx_data(din), .ttx_req(req), .bit_out(bout),
        .bit_valid(bval), .win_active(wact)
    );

    always #5 clk = ~clk;

    // Behavioural reference model, advanced on each rising edge.
    int m_state = 0, m_dly = 0, m_left = 0, m_acc = 0;
    bit m_req = 0, m_tog = 0, m_valid = 0, m_bit = 0;
    bit m_hist[$];

    function automatic int nbits(input logic [1:0] s);
        return (s == 0) ? 360 : (s == 1) ? 296 : 288;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_dly = 0; m_left = 0; m_acc = 0;
            m_req = 0; m_tog = 0; m_valid = 0; m_bit = 0;
            m_hist = {};
            for (int i = 0; i < 15; i++) m_hist.push_back(1'b0);
        end else begin
            bit smp, on, issue;
            smp = (lat == 0) ? m_req : m_hist[lat - 1];
            m_valid = smp && !cko;
            if (m_valid) m_bit = din;
            m_hist.push_front(m_req);
            void'(m_hist.pop_back());
            on = en && !rtc && !cko;
            issue = 0;
            if (!on) m_state = 0;
            else if (m_state == 0) begin
                if (ls && line < 32 && (fld ? set2[line[4:0]] : set1[line[4:0]])) begin
                    m_state = 1; m_dly = sdly;
                end
            end else if (m_state == 1) begin
                if (m_dly == 0) begin m_state = 2; m_left = nbits(std); m_acc = 0; end
                else m_dly--;
            end else begin
                m_acc += inc;
                if (m_acc >= 65536) begin
                    m_acc -= 65536; issue = 1; m_left--;
                    if (m_left == 0) m_state = 0;
                end
            end
            m_req = issue;
            m_tog = cko ? !m_tog : 1'b0;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // Compare against the model away from the active edge; drive data.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            check(cko ? "R8 ttx_req clock" : "R5 ttx_req", req, cko ? m_tog : m_req);
            check("R3 win_active", wact, m_state == 2);
            check("R7 bit_valid", bval, m_valid);
            if (m_valid) check("R7 bit_out", bout, m_bit);
            if (!cko && req && !prev_req) pulses++;
            prev_req = req;
        end
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        din = lfsr[0];
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_line(input bit f, input int ln);
        @(negedge clk);
        fld = f; line = 10'(ln); ls = 1'b1;
        @(negedge clk);
        ls = 1'b0;
    endtask

    task automatic wait_window_end();
        int g = 0;
        while (!wact && g < 5000) begin @(negedge clk); g++; end
        while (wact && g < 20000) begin @(negedge clk); g++; end
        tick(40);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        tick(4);
        check("R1 ttx_req in reset", req, 0);
        check("R1 win_active in reset", wact, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 bit_valid after reset", bval, 0);
        check("R1 win_active after reset", wact, 0);
        en = 1'b1; set1 = 32'h0000_0400; set2 = 32'h0010_0000;

        // PAL, field 1 line 10
        pulses = 0; std = 0; inc = 16'd16837; sdly = 5; lat = 3;
        start_line(0, 10); wait_window_end();
        check("R4 PAL pulse count", pulses, 360);

        // R2: line not in second-field set
        pulses = 0; start_line(1, 10); tick(300);
        check("R2 unselected line pulses", pulses, 0);

        // NTSC, field 2 line 20, zero latency
        pulses = 0; std = 1; inc = 16'd20000; sdly = 0; lat = 0;
        start_line(1, 20); wait_window_end();
        check("R4 NTSC pulse count", pulses, 296);

        // NABTS with a line start inside the window (R6), max latency
        pulses = 0; std = 2; inc = 16'd32767; sdly = 17; lat = 15;
        start_line(0, 10); tick(100); start_line(0, 10);
        wait_window_end();
        check("R6 NABTS count with extra line start", pulses, 288);

        // Code 3 behaves as NABTS
        pulses = 0; std = 3; inc = 16'd9000; sdly = 2; lat = 7;
        start_line(0, 10); wait_window_end();
        check("R4 code 3 pulse count", pulses, 288);

        // R2: line outside the mask range
        pulses = 0; set1 = '1; start_line(0, 40); tick(300);
        check("R2 out-of-range line pulses", pulses, 0);

        // R9: real-time control aborts the window
        pulses = 0; std = 0; inc = 16'd16837; lat = 2;
        start_line(0, 10); tick(200); rtc = 1'b1; tick(100);
        check("R9 window closed by rtc", wact, 0);
        check("R9 truncated count", pulses < 360, 1);
        rtc = 1'b0;
        pulses = 0; start_line(0, 10); tick(100); en = 1'b0; tick(100);
        check("R9 window closed by disable", wact, 0);
        en = 1'b1;

        // R8: clock output mode
        cko = 1'b1; start_line(0, 10); tick(60);
        check("R8 no window in clock mode", wact, 0);
        cko = 1'b0; tick(20);
        pulses = 0; std = 1; inc = 16'd5000; sdly = 1; lat = 1;
        start_line(0, 10); wait_window_end();
        check("R4 NTSC after clock mode", pulses, 296);

        finish_up();
    end
endmodule